// File: doc/BRIEF.md
# Compare-Value System Timer Channel

This block is one timer channel that sits beside a free-running 64-bit system counter and raises a level interrupt once the counter has caught up with a programmed deadline. Software sets the deadline in one of two ways. It can write an absolute 64-bit compare value. It can also write a signed 32-bit relative delay, which the channel adds to the present counter value. Both forms describe the same stored deadline: writing one changes what the other reads back.

A small control word holds an enable flag, an interrupt mask flag and a live status flag. The status flag always shows whether the deadline has been reached, even while the interrupt is masked. A read-only frequency word reports the counter tick rate, from which software derives its delays.

The register bus has no back-pressure. A request on `bus_valid_i` is taken on every clock edge where it is high. A write takes effect at that edge. A read returns its data on `bus_rdata_o` together with a one-cycle `bus_rvalid_o` pulse in the following cycle. The read data shows the register values as they stood before any write in the same cycle.

Top module: `cmp_timer_channel`

## Requirements
- R1: After reset the counter, the compare value and the control flags are all zero, and `irq_o` is low. Because 0 ≥ 0, the control word therefore reads 4: status set, enable and mask clear.
- R2: The counter grows by one at each clock edge where `tick_i` is high. Otherwise it holds. A bus write to word address 0 loads the counter, and such a load takes priority over a tick.
- R3: The status flag, bit 2 of the control word at word address 3, is 1 exactly when the counter is greater than or equal to the compare value, compared as unsigned 64-bit numbers. It is never 1 before the counter reaches the compare value.
- R4: `irq_o` is a registered signal equal to enable (control bit 0) AND status AND NOT mask (control bit 1). It is evaluated at each clock edge from the state before that edge, so it follows any counter or register change one cycle later.
- R5: While the mask flag is set, the status flag still reads the condition, but `irq_o` stays low.
- R6: Writing 0 to the control word clears enable. `irq_o` is low from the next cycle on, and the control word no longer reports enable and status together.
- R7: Writing a compare value (word address 1) that is at or below the present counter, while the channel is enabled and unmasked, raises `irq_o` one cycle after the write.
- R8: Writing value T to the down-count word (word address 2) sets the compare value to the counter plus T[31:0], sign-extended to 64 bits.
- R9: Reading the down-count word returns compare minus counter, cut to 32 bits and sign-extended to 64 bits. It reads zero or negative once the deadline has passed.
- R10: The frequency word (word address 4) reads the `FREQ_HZ` parameter, and writes to it have no effect.
- R11: Writes to the control word store only bits 0 and 1. The written value of bit 2 is ignored, and bits 63..3 read as zero.
- R12: A read produces `bus_rvalid_o` high for exactly the next cycle, with the data. A write produces no `bus_rvalid_o`. Unused word addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Counter advance enable, one increment per cycle |
| bus_valid_i | input | 1 | Register request, taken on every edge where it is high |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Word address: 0 counter, 1 compare, 2 down-count, 3 control, 4 frequency |
| bus_wdata_i | input | 64 | Write data |
| bus_rdata_o | output | 64 | Read data, valid while bus_rvalid_o is high |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| irq_o | output | 1 | Level interrupt toward the interrupt controller |

## Verification
The bench builds the channel with a 64-bit counter and a 32-bit down-count view, as in a real system. It sets `FREQ_HZ` to 1000, so a tenth of a second is a delay of 100 ticks and can be reached within a few hundred cycles. With those widths it checks the sign-extension of negative and near-maximum relative delays across the 32-to-64-bit boundary. It also checks the exact edge at which the counter meets the compare value, with the interrupt sampled once before and once after its one-cycle register delay.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    SEL_COUNT = 3'd0,
    SEL_CMP   = 3'd1,
    SEL_DOWN  = 3'd2,
    SEL_CTL   = 3'd3,
    SEL_FREQ  = 3'd4
  } reg_sel_e;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_MASK_BIT = 1;
  localparam int CTL_STAT_BIT = 2;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int CNT_W  = 64,
  parameter int DCNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_wr_i,
  input  logic             down_wr_i,
  input  logic             ctl_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic [CNT_W-1:0] down_o,
  output logic             en_o,
  output logic             mask_o,
  output logic             status_o,
  output logic             irq_o
);
  localparam int EXT_W = CNT_W - DCNT_W;

  logic [CNT_W-1:0] cmp_q;
  logic             en_q, mask_q, irq_q;
  logic [CNT_W-1:0] wdata_sext;
  logic [CNT_W-1:0] diff;

  assign diff = cmp_q - count_i;

  generate
    if (EXT_W > 0) begin : g_ext
      assign wdata_sext = {{EXT_W{wdata_i[DCNT_W-1]}}, wdata_i[DCNT_W-1:0]};
      assign down_o     = {{EXT_W{diff[DCNT_W-1]}}, diff[DCNT_W-1:0]};
    end else begin : g_noext
      assign wdata_sext = wdata_i;
      assign down_o     = diff;
    end
  endgenerate

  assign status_o = (count_i >= cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      en_q   <= 1'b0;
      mask_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (cmp_wr_i)       cmp_q <= wdata_i;
      else if (down_wr_i) cmp_q <= count_i + wdata_sext;
      if (ctl_wr_i) begin
        en_q   <= wdata_i[tmr_pkg::CTL_EN_BIT];
        mask_q <= wdata_i[tmr_pkg::CTL_MASK_BIT];
      end
      irq_q <= en_q & status_o & ~mask_q;
    end
  end

  assign cmp_o  = cmp_q;
  assign en_o   = en_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/tmr_readback.sv
module tmr_readback #(
  parameter int          CNT_W   = 64,
  parameter int unsigned FREQ_HZ = 50000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_i,
  input  logic [2:0]       addr_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] down_i,
  input  logic             en_i,
  input  logic             mask_i,
  input  logic             status_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             rvalid_o
);
  import tmr_pkg::*;

  logic [CNT_W-1:0] mux;
  logic [CNT_W-1:0] ctl_word;

  always_comb begin
    ctl_word = '0;
    ctl_word[CTL_EN_BIT]   = en_i;
    ctl_word[CTL_MASK_BIT] = mask_i;
    ctl_word[CTL_STAT_BIT] = status_i;
  end

  always_comb begin
    case (reg_sel_e'(addr_i))
      SEL_COUNT: mux = count_i;
      SEL_CMP:   mux = cmp_i;
      SEL_DOWN:  mux = down_i;
      SEL_CTL:   mux = ctl_word;
      SEL_FREQ:  mux = CNT_W'(FREQ_HZ);
      default:   mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= mux;
    end
  end
endmodule

// File: rtl/cmp_timer_channel.sv
module cmp_timer_channel #(
  parameter int          CNT_W   = 64,
  parameter int          DCNT_W  = 32,
  parameter int unsigned FREQ_HZ = 50000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             bus_valid_i,
  input  logic             bus_write_i,
  input  logic [2:0]       bus_addr_i,
  input  logic [CNT_W-1:0] bus_wdata_i,
  output logic [CNT_W-1:0] bus_rdata_o,
  output logic             bus_rvalid_o,
  output logic             irq_o
);
  import tmr_pkg::*;

  logic             wr, rd;
  logic [CNT_W-1:0] count_w, cmp_w, down_w;
  logic             en_w, mask_w, status_w;

  assign wr = bus_valid_i & bus_write_i;
  assign rd = bus_valid_i & ~bus_write_i;

  tmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .load_i     (wr && bus_addr_i == SEL_COUNT),
    .load_val_i (bus_wdata_i),
    .count_o    (count_w)
  );

  tmr_compare #(.CNT_W(CNT_W), .DCNT_W(DCNT_W)) u_compare (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_wr_i  (wr && bus_addr_i == SEL_CMP),
    .down_wr_i (wr && bus_addr_i == SEL_DOWN),
    .ctl_wr_i  (wr && bus_addr_i == SEL_CTL),
    .wdata_i   (bus_wdata_i),
    .count_i   (count_w),
    .cmp_o     (cmp_w),
    .down_o    (down_w),
    .en_o      (en_w),
    .mask_o    (mask_w),
    .status_o  (status_w),
    .irq_o     (irq_o)
  );

  tmr_readback #(.CNT_W(CNT_W), .FREQ_HZ(FREQ_HZ)) u_readback (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_i     (rd),
    .addr_i   (bus_addr_i),
    .count_i  (count_w),
    .cmp_i    (cmp_w),
    .down_i   (down_w),
    .en_i     (en_w),
    .mask_i   (mask_w),
    .status_i (status_w),
    .rdata_o  (bus_rdata_o),
    .rvalid_o (bus_rvalid_o)
  );
endmodule

// File: rtl/tmr_channel_checker.sv
module tmr_channel_checker #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             bus_valid_i,
  input logic             bus_write_i,
  input logic [2:0]       bus_addr_i,
  input logic             bus_rvalid_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] count_w,
  input logic [CNT_W-1:0] cmp_w,
  input logic             en_w,
  input logic             mask_w
);
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !(bus_valid_i && bus_write_i && bus_addr_i == 3'd0)) |=> $stable(count_w));

  assert_irq_not_early_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(count_w >= cmp_w));

  assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_w && !mask_w && (count_w >= cmp_w)) |-> irq_o);

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mask_w) |-> !irq_o);

  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en_w) |-> !irq_o);

  assert_rvalid_timing_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_i && !bus_write_i) |=> bus_rvalid_o);

  assert_no_rvalid_on_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_valid_i || bus_write_i) |=> !bus_rvalid_o);
endmodule

bind cmp_timer_channel tmr_channel_checker #(.CNT_W(CNT_W)) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_i       (tick_i),
  .bus_valid_i  (bus_valid_i),
  .bus_write_i  (bus_write_i),
  .bus_addr_i   (bus_addr_i),
  .bus_rvalid_o (bus_rvalid_o),
  .irq_o        (irq_o),
  .count_w      (count_w),
  .cmp_w        (cmp_w),
  .en_w         (en_w),
  .mask_w       (mask_w)
);

// File: tb/cmp_timer_channel_bench.sv
module cmp_timer_channel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 64;
  localparam int DCNT_W = 32;
  localparam int unsigned FREQ = 1000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0;
  logic             bv = 1'b0;
  logic             bw = 1'b0;
  logic [2:0]       ba = '0;
  logic [CNT_W-1:0] bwd = '0;
  logic [CNT_W-1:0] brd;
  logic             brv;
  logic             irq;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  cmp_timer_channel #(.CNT_W(CNT_W), .DCNT_W(DCNT_W), .FREQ_HZ(FREQ)) u_cmp_timer_channel (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_valid_i(bv), .bus_write_i(bw),
    .bus_addr_i(ba), .bus_wdata_i(bwd), .bus_rdata_o(brd), .bus_rvalid_o(brv), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [CNT_W-1:0] d);
    @(negedge clk);
    bv = 1'b1; bw = 1'b1; ba = a; bwd = d;
    @(posedge clk);
    @(negedge clk);
    bv = 1'b0; bw = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [CNT_W-1:0] d);
    @(negedge clk);
    bv = 1'b1; bw = 1'b0; ba = a;
    @(posedge clk);
    @(negedge clk);
    bv = 1'b0;
    chk("R12 rvalid after read", CNT_W'(brv), 1);
    d = brd;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [CNT_W-1:0] v;
    chk("R1 irq low after reset", CNT_W'(irq), 0);
    bus_rd(3'd0, v); chk("R1 counter zero", v, 0);
    bus_rd(3'd1, v); chk("R1 compare zero", v, 0);
    bus_rd(3'd3, v); chk("R1 control reads 4", v, 4);
  endtask

  task automatic t_count();
    logic [CNT_W-1:0] v;
    run_ticks(5);
    bus_rd(3'd0, v); chk("R2 counter after 5 ticks", v, 5);
    bus_rd(3'd0, v); chk("R2 counter holds without tick", v, 5);
    bus_wr(3'd0, 64'd100);
    chk("R12 no rvalid after write", CNT_W'(brv), 0);
    bus_rd(3'd0, v); chk("R2 counter load", v, 100);
    bus_rd(3'd6, v); chk("R12 unused address reads zero", v, 0);
  endtask

  task automatic t_expire();
    logic [CNT_W-1:0] v;
    bus_wr(3'd1, 64'd110);
    bus_wr(3'd3, 64'd1);
    bus_rd(3'd3, v); chk("R3 status clear before deadline", v, 1);
    run_ticks(9);
    bus_rd(3'd3, v); chk("R3 status clear one tick early", v, 1);
    chk("R4 irq low one tick early", CNT_W'(irq), 0);
    run_ticks(1);
    chk("R4 irq not yet set in edge of match", CNT_W'(irq), 0);
    @(negedge clk);
    chk("R4 irq set one cycle after match", CNT_W'(irq), 1);
    bus_rd(3'd3, v); chk("R3 status set at match", v, 5);
  endtask

  task automatic t_mask_disable();
    logic [CNT_W-1:0] v;
    bus_wr(3'd3, 64'd3);
    @(negedge clk);
    chk("R5 irq low while masked", CNT_W'(irq), 0);
    bus_rd(3'd3, v); chk("R5 status still set while masked", v, 7);
    bus_wr(3'd3, 64'd1);
    @(negedge clk);
    chk("R4 irq returns on unmask", CNT_W'(irq), 1);
    bus_wr(3'd3, 64'd0);
    @(negedge clk);
    chk("R6 irq drops after disable", CNT_W'(irq), 0);
    bus_rd(3'd3, v); chk("R6 no longer pending", v, 4);
  endtask

  task automatic t_past();
    bus_wr(3'd1, 64'd5000);
    bus_wr(3'd3, 64'd1);
    @(negedge clk);
    chk("R7 irq low with future deadline", CNT_W'(irq), 0);
    bus_wr(3'd1, 64'd109);
    chk("R7 irq not in write cycle", CNT_W'(irq), 0);
    @(negedge clk);
    chk("R7 irq after past compare", CNT_W'(irq), 1);
    bus_wr(3'd3, 64'd0);
  endtask

  task automatic t_down();
    logic [CNT_W-1:0] v;
    bus_wr(3'd2, 64'd50);
    bus_rd(3'd1, v); chk("R8 compare after down write 50", v, 160);
    bus_rd(3'd2, v); chk("R9 down read 50", v, 50);
    bus_wr(3'd2, 64'h0000_0000_FFFF_FFFB);
    bus_rd(3'd1, v); chk("R8 compare after negative down write", v, 105);
    bus_rd(3'd2, v); chk("R9 down read negative", v, 64'hFFFF_FFFF_FFFF_FFFB);
    bus_wr(3'd2, 64'hABCD_0000_7FFF_FFFF);
    bus_rd(3'd1, v); chk("R8 compare with max positive delay", v, 64'd110 + 64'h7FFF_FFFF);
  endtask

  task automatic t_freq();
    logic [CNT_W-1:0] v;
    bus_rd(3'd4, v); chk("R10 frequency", v, FREQ);
    bus_wr(3'd4, 64'd777);
    bus_rd(3'd4, v); chk("R10 frequency ignores write", v, FREQ);
    bus_wr(3'd2, CNT_W'(FREQ / 10));
    bus_wr(3'd3, 64'd1);
    run_ticks(FREQ / 10 - 1);
    @(negedge clk);
    chk("R4 irq low before tenth second", CNT_W'(irq), 0);
    run_ticks(1);
    @(negedge clk);
    chk("R4 irq after tenth second", CNT_W'(irq), 1);
    bus_rd(3'd2, v); chk("R9 down reads zero at expiry", v, 0);
    run_ticks(3);
    bus_rd(3'd2, v); chk("R9 down negative after expiry", v, 64'hFFFF_FFFF_FFFF_FFFD);
    bus_wr(3'd3, 64'd0);
  endtask

  task automatic t_status_ro();
    logic [CNT_W-1:0] v;
    bus_wr(3'd1, 64'hFFFF_0000_0000_0000);
    bus_wr(3'd3, 64'd4);
    bus_rd(3'd3, v); chk("R11 status write ignored", v, 0);
    bus_wr(3'd3, {CNT_W{1'b1}});
    bus_rd(3'd3, v); chk("R11 only enable and mask stored", v, 3);
    @(negedge clk);
    chk("R11 irq low with future deadline", CNT_W'(irq), 0);
    bus_wr(3'd3, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_expire();
    t_mask_disable();
    t_past();
    t_down();
    t_freq();
    t_status_ro();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule